// File: doc/BRIEF.md
# Configurable Register Field With Selectable Access Policy

This block is one field of a memory-mapped control/status register. A compile-time parameter picks how software may touch the field. There are 29 policies:

- plain read/write and read-only storage;
- clear-on-read and set-on-read;
- set, clear or toggle applied bitwise by writing ones or by writing zeros;
- clear or set on any write, whatever the data;
- write-once after a hard reset;
- write-only and not-accessible variants;
- single-cycle pulse generators.

Software reaches the field through a read strobe, a write strobe, write data and read data. Hardware can load the field through its own write enable and value, and it sees the stored value and a pulse vector.

A bus decoder instantiates one slice per field and gives it its strobes. The decoder packs the read data of the slices into a word. The read data always shows the value held before any read side effect of the same cycle. When several sources act in one cycle, a fixed priority settles the outcome: a read side effect first, then an accepted software write, then the hardware write.

Top module: `regfld_slice`

## Requirements
- R1: For the read/write policy, a software write stores the write data. For the read-only policy, software writes are ignored. For both, when no software write is accepted, an asserted hardware write enable loads the hardware value on the next clock edge.
- R2: For the write-one-to-clear, write-one-to-set and write-one-to-toggle policies, only the bits written as 1 are cleared, set or inverted. Bits written as 0 keep their value.
- R3: For the write-zero-to-clear, write-zero-to-set and write-zero-to-toggle policies, only the bits written as 0 are cleared, set or inverted. Bits written as 1 keep their value.
- R4: The clear-on-read and set-on-read policies ignore software writes. A read returns the current value, and after the clock edge the field is all zeros (clear-on-read) or all ones (set-on-read).
- R5: The clear-on-any-write and set-on-any-write policies force the whole field to zeros or to ones on every software write, whatever the write data.
- R6: The combined policies apply both a write effect and a read effect:
  - writes store the data, and a read clears or sets the field;
  - any write sets the field and a read clears it, or any write clears it and a read sets it;
  - writing ones sets bits and a read clears the field, or writing ones clears bits and a read sets the field;
  - the same two pairings with zeros as the active write value.
- R7: For the write-once policies, the first software write after a hard reset is stored as given. Every later software write leaves the field unchanged until the next hard reset.
- R8: For the pulse-on-one policies, a write drives each bit written as 1 high on the pulse output for exactly one cycle. The registered variant does this in the cycle after the write. The combinational variant does it during the write cycle. In both variants the field output shows the registered copy of the pulse, and the read data is zero.
- R9: For the pulse-on-zero policy, a write drives each bit written as 0 high on the pulse output for exactly one cycle, in the cycle after the write. The field output equals the pulse output, and the read data is zero.
- R10: The write-only policies (store, clear-on-write, set-on-write and write-once) always return zero read data. The not-accessible policy returns zero read data and ignores software writes.
- R11: When sources collide in one cycle, a read side effect wins over a software write, and an accepted software write wins over a hardware write.
- R12: A hard reset returns every stored policy to the parameterised reset value, returns the pulse policies to zero, and clears the write-once lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| sw_rd_i | input | 1 | Software read strobe for this field |
| sw_wr_i | input | 1 | Software write strobe for this field |
| sw_wdata_i | input | WIDTH | Software write data |
| sw_rdata_o | output | WIDTH | Software read data, showing the value before any read side effect |
| hw_we_i | input | 1 | Hardware write enable |
| hw_wdata_i | input | WIDTH | Hardware write value |
| field_o | output | WIDTH | Current field value seen by hardware |
| pulse_o | output | WIDTH | Pulse vector for the pulse policies, zero otherwise |

## Verification
The assertions assume that the strobes, data and reset are always driven to known levels. They also assume that inputs change only between rising edges and that reset is held across at least one rising edge.

The bench drives every input from a single process at the falling edge, using defined pseudo-random values. It biases write data towards all-zero and all-one words so that the bitwise policies meet their boundary cases. Reset is asserted at a falling edge for a full cycle, and always in the middle of running traffic, so that the write-once lock and the pulse registers are cleared while busy.

// File: rtl/regfld_pkg.sv
package regfld_pkg;

   typedef enum logic [4:0] {
      FA_RO, FA_RW, FA_RD_CLR, FA_RD_SET,
      FA_RW_RD_CLR, FA_RW_RD_SET,
      FA_ANYW_CLR, FA_ANYW_SET, FA_ANYW_SET_RD_CLR, FA_ANYW_CLR_RD_SET,
      FA_W1_CLR, FA_W1_SET, FA_W1_TGL,
      FA_W0_CLR, FA_W0_SET, FA_W0_TGL,
      FA_W1_SET_RD_CLR, FA_W1_CLR_RD_SET, FA_W0_SET_RD_CLR, FA_W0_CLR_RD_SET,
      FA_WO, FA_WO_CLR, FA_WO_SET, FA_ONCE, FA_WO_ONCE, FA_NONE,
      FA_PLS1_REG, FA_PLS1_COMB, FA_PLS0_REG
   } fld_acc_e;

   localparam int FLD_ACC_NUM = 29;

   typedef enum logic [1:0] {RDE_NONE, RDE_CLR, RDE_SET} fld_rde_e;
   typedef enum logic [1:0] {PLS_NONE, PLS_ONE_REG, PLS_ONE_COMB, PLS_ZERO_REG} fld_pls_e;

   function automatic fld_rde_e fld_rd_effect(fld_acc_e p);
      case (p)
         FA_RD_CLR, FA_RW_RD_CLR, FA_ANYW_SET_RD_CLR,
         FA_W1_SET_RD_CLR, FA_W0_SET_RD_CLR:               return RDE_CLR;
         FA_RD_SET, FA_RW_RD_SET, FA_ANYW_CLR_RD_SET,
         FA_W1_CLR_RD_SET, FA_W0_CLR_RD_SET:               return RDE_SET;
         default:                                           return RDE_NONE;
      endcase
   endfunction

   function automatic fld_pls_e fld_pulse_kind(fld_acc_e p);
      case (p)
         FA_PLS1_REG:  return PLS_ONE_REG;
         FA_PLS1_COMB: return PLS_ONE_COMB;
         FA_PLS0_REG:  return PLS_ZERO_REG;
         default:      return PLS_NONE;
      endcase
   endfunction

   function automatic bit fld_readable(fld_acc_e p);
      case (p)
         FA_WO, FA_WO_CLR, FA_WO_SET, FA_WO_ONCE, FA_NONE,
         FA_PLS1_REG, FA_PLS1_COMB, FA_PLS0_REG: return 1'b0;
         default:                                return 1'b1;
      endcase
   endfunction

   function automatic bit fld_once(fld_acc_e p);
      return (p == FA_ONCE) || (p == FA_WO_ONCE);
   endfunction

endpackage

// File: rtl/regfld_wr_eff.sv
module regfld_wr_eff
   import regfld_pkg::*;
#(
   parameter int       WIDTH  = 8,
   parameter fld_acc_e POLICY = FA_RW
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             locked_i,
   output logic [WIDTH-1:0] nxt_o,
   output logic             take_o
);

   localparam logic [WIDTH-1:0] ALL_ONE = '1;

   // Value the field takes if a software write is accepted; take_o says whether it is.
   always_comb begin
      take_o = 1'b1;
      nxt_o  = cur_i;
      case (POLICY)
         FA_RW, FA_RW_RD_CLR, FA_RW_RD_SET, FA_WO:          nxt_o = wdata_i;
         FA_ANYW_CLR, FA_ANYW_CLR_RD_SET, FA_WO_CLR:        nxt_o = '0;
         FA_ANYW_SET, FA_ANYW_SET_RD_CLR, FA_WO_SET:        nxt_o = ALL_ONE;
         FA_W1_CLR, FA_W1_CLR_RD_SET:                       nxt_o = cur_i & ~wdata_i;
         FA_W1_SET, FA_W1_SET_RD_CLR:                       nxt_o = cur_i | wdata_i;
         FA_W1_TGL:                                         nxt_o = cur_i ^ wdata_i;
         FA_W0_CLR, FA_W0_CLR_RD_SET:                       nxt_o = cur_i & wdata_i;
         FA_W0_SET, FA_W0_SET_RD_CLR:                       nxt_o = cur_i | ~wdata_i;
         FA_W0_TGL:                                         nxt_o = cur_i ^ ~wdata_i;
         FA_ONCE, FA_WO_ONCE: begin
            take_o = ~locked_i;
            nxt_o  = locked_i ? cur_i : wdata_i;
         end
         default:                                           take_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/regfld_rd_eff.sv
module regfld_rd_eff
   import regfld_pkg::*;
#(
   parameter int       WIDTH  = 8,
   parameter fld_acc_e POLICY = FA_RW
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             fire_o,
   output logic [WIDTH-1:0] after_o
);

   localparam fld_rde_e RDE      = fld_rd_effect(POLICY);
   localparam bit       READABLE = fld_readable(POLICY);

   // Read data always reflects the value before this cycle's read effect.
   always_comb rdata_o = READABLE ? cur_i : '0;

   generate
      if (RDE == RDE_CLR) begin : g_clr
         assign fire_o  = 1'b1;
         assign after_o = '0;
      end else if (RDE == RDE_SET) begin : g_set
         assign fire_o  = 1'b1;
         assign after_o = '1;
      end else begin : g_none
         assign fire_o  = 1'b0;
         assign after_o = '0;
      end
   endgenerate

endmodule

// File: rtl/regfld_pulse.sv
module regfld_pulse
   import regfld_pkg::*;
#(
   parameter int       WIDTH = 8,
   parameter fld_pls_e KIND  = PLS_ONE_REG
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] held_o,
   output logic [WIDTH-1:0] pulse_o
);

   localparam bit ACT_LOW = (KIND == PLS_ZERO_REG);

   logic [WIDTH-1:0] held_q;

   // Self-clearing register: holds one cycle of write-derived bits.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   held_q <= '0;
      else if (wr_i) held_q <= ACT_LOW ? ~wdata_i : wdata_i;
      else           held_q <= '0;
   end

   assign held_o = held_q;

   generate
      if (KIND == PLS_ONE_COMB) begin : g_comb
         assign pulse_o = wr_i ? wdata_i : '0;
      end else begin : g_reg
         assign pulse_o = held_q;
      end
   endgenerate

endmodule

// File: rtl/regfld_slice.sv
module regfld_slice
   import regfld_pkg::*;
#(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0,
   parameter fld_acc_e         POLICY  = FA_RW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sw_rd_i,
   input  logic             sw_wr_i,
   input  logic [WIDTH-1:0] sw_wdata_i,
   output logic [WIDTH-1:0] sw_rdata_o,
   input  logic             hw_we_i,
   input  logic [WIDTH-1:0] hw_wdata_i,
   output logic [WIDTH-1:0] field_o,
   output logic [WIDTH-1:0] pulse_o
);

   localparam fld_pls_e PLS  = fld_pulse_kind(POLICY);
   localparam fld_rde_e RDE  = fld_rd_effect(POLICY);
   localparam bit       ONCE = fld_once(POLICY);

   initial begin
      AST_WIDTH_RANGE: assert (WIDTH >= 1 && WIDTH <= 64)
         else $error("regfld_slice: WIDTH %0d outside 1..64", WIDTH);
   end

   logic [WIDTH-1:0] val_q;
   logic             lock_q;
   logic [WIDTH-1:0] wr_nxt, rd_after;
   logic             wr_take, rd_fire;

   regfld_wr_eff #(.WIDTH(WIDTH), .POLICY(POLICY)) i_wr_eff (
      .cur_i    (val_q),
      .wdata_i  (sw_wdata_i),
      .locked_i (lock_q),
      .nxt_o    (wr_nxt),
      .take_o   (wr_take)
   );

   regfld_rd_eff #(.WIDTH(WIDTH), .POLICY(POLICY)) i_rd_eff (
      .cur_i   (val_q),
      .rdata_o (sw_rdata_o),
      .fire_o  (rd_fire),
      .after_o (rd_after)
   );

   // Priority: read side effect, then accepted software write, then hardware.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  val_q <= RST_VAL;
      else if (sw_rd_i && rd_fire)  val_q <= rd_after;
      else if (sw_wr_i && wr_take)  val_q <= wr_nxt;
      else if (hw_we_i)             val_q <= hw_wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          lock_q <= 1'b0;
      else if (ONCE && sw_wr_i && wr_take)  lock_q <= 1'b1;
   end

   generate
      if (PLS != PLS_NONE) begin : g_pulse
         logic [WIDTH-1:0] held;
         regfld_pulse #(.WIDTH(WIDTH), .KIND(PLS)) i_pulse (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (sw_wr_i),
            .wdata_i (sw_wdata_i),
            .held_o  (held),
            .pulse_o (pulse_o)
         );
         assign field_o = held;
         if (PLS != PLS_ONE_COMB) begin : g_a_pls
            AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
               !sw_wr_i |=> pulse_o == '0);                               // R8
         end
      end else begin : g_store
         assign field_o = val_q;
         assign pulse_o = '0;
      end

      if (RDE == RDE_CLR) begin : g_a_rclr
         AST_RDCLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sw_rd_i |=> field_o == '0);                                    // R4
      end
      if (RDE == RDE_SET) begin : g_a_rset
         AST_RDSET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sw_rd_i |=> field_o == '1);                                    // R4
      end
      if (ONCE) begin : g_a_once
         AST_ONCE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lock_q && sw_wr_i && !hw_we_i) |=> $stable(field_o));         // R7
      end
      if (POLICY == FA_NONE) begin : g_a_none
         AST_NONE_IGNORES_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sw_wr_i && !hw_we_i) |=> $stable(field_o));                   // R10
      end
      if (POLICY == FA_RW) begin : g_a_rw
         AST_SW_BEATS_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sw_wr_i && hw_we_i) |=> field_o == $past(sw_wdata_i));        // R11
      end
      if (POLICY == FA_W1_CLR) begin : g_a_w1c
         AST_W1_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sw_wr_i |=> (field_o & $past(sw_wdata_i)) == '0);              // R2
      end
   endgenerate

endmodule

// File: tb/test_regfld_slice.sv
module test_regfld_slice;
   import regfld_pkg::*;

   localparam int           W   = 8;
   localparam logic [W-1:0] RV  = 8'hA5;
   localparam int           NP  = FLD_ACC_NUM;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic         rst_n, rd, wr, hwe;
   logic [W-1:0] wd, hwd;
   logic [W-1:0] fo [NP];
   logic [W-1:0] ro [NP];
   logic [W-1:0] po [NP];

   generate
      for (genvar g = 0; g < NP; g++) begin : g_pol
         regfld_slice #(.WIDTH(W), .RST_VAL(RV), .POLICY(fld_acc_e'(g))) i_regfld_slice (
            .clk_i(clk), .rst_ni(rst_n), .sw_rd_i(rd), .sw_wr_i(wr), .sw_wdata_i(wd),
            .sw_rdata_o(ro[g]), .hw_we_i(hwe), .hw_wdata_i(hwd),
            .field_o(fo[g]), .pulse_o(po[g]));
      end
   endgenerate

   logic [W-1:0] m_val [NP];
   bit           m_lock [NP];
   int checks = 0;
   int errors = 0;

   function automatic bit is_pulse(fld_acc_e a);
      return a inside {FA_PLS1_REG, FA_PLS1_COMB, FA_PLS0_REG};
   endfunction

   function automatic bit can_read(fld_acc_e a);
      return !(a inside {FA_WO, FA_WO_CLR, FA_WO_SET, FA_WO_ONCE, FA_NONE}) && !is_pulse(a);
   endfunction

   function automatic string req_of(fld_acc_e a);
      if (a inside {FA_RO, FA_RW}) return "R1";
      if (a inside {FA_W1_CLR, FA_W1_SET, FA_W1_TGL}) return "R2";
      if (a inside {FA_W0_CLR, FA_W0_SET, FA_W0_TGL}) return "R3";
      if (a inside {FA_RD_CLR, FA_RD_SET}) return "R4";
      if (a inside {FA_ANYW_CLR, FA_ANYW_SET}) return "R5";
      if (a inside {FA_ONCE, FA_WO_ONCE}) return "R7";
      if (a inside {FA_PLS1_REG, FA_PLS1_COMB}) return "R8";
      if (a == FA_PLS0_REG) return "R9";
      if (a inside {FA_WO, FA_WO_CLR, FA_WO_SET, FA_NONE}) return "R10";
      return "R6";
   endfunction

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         m_val[p]  = is_pulse(fld_acc_e'(p)) ? '0 : RV;
         m_lock[p] = 1'b0;
      end
   endtask

   // Behavioural next-state for one policy given the inputs seen at the last edge.
   task automatic model_step();
      for (int p = 0; p < NP; p++) begin
         fld_acc_e     a   = fld_acc_e'(p);
         logic [W-1:0] v   = m_val[p];
         bit           rdc = a inside {FA_RD_CLR, FA_RW_RD_CLR, FA_ANYW_SET_RD_CLR,
                                       FA_W1_SET_RD_CLR, FA_W0_SET_RD_CLR};
         bit           rds = a inside {FA_RD_SET, FA_RW_RD_SET, FA_ANYW_CLR_RD_SET,
                                       FA_W1_CLR_RD_SET, FA_W0_CLR_RD_SET};
         bit           acc = 1'b1;
         logic [W-1:0] wv  = v;
         if (is_pulse(a)) begin
            m_val[p] = !wr ? '0 : (a == FA_PLS0_REG ? ~wd : wd);
            continue;
         end
         if (a inside {FA_RW, FA_RW_RD_CLR, FA_RW_RD_SET, FA_WO}) wv = wd;
         else if (a inside {FA_ANYW_CLR, FA_ANYW_CLR_RD_SET, FA_WO_CLR}) wv = 8'h00;
         else if (a inside {FA_ANYW_SET, FA_ANYW_SET_RD_CLR, FA_WO_SET}) wv = 8'hFF;
         else if (a inside {FA_W1_CLR, FA_W1_CLR_RD_SET}) wv = v & ~wd;
         else if (a inside {FA_W1_SET, FA_W1_SET_RD_CLR}) wv = v | wd;
         else if (a == FA_W1_TGL) wv = v ^ wd;
         else if (a inside {FA_W0_CLR, FA_W0_CLR_RD_SET}) wv = v & wd;
         else if (a inside {FA_W0_SET, FA_W0_SET_RD_CLR}) wv = v | ~wd;
         else if (a == FA_W0_TGL) wv = ~(v ^ wd);
         else if (a inside {FA_ONCE, FA_WO_ONCE}) begin
            acc = !m_lock[p];
            wv  = wd;
         end else acc = 1'b0;
         if (rd && rdc)       v = 8'h00;
         else if (rd && rds)  v = 8'hFF;
         else if (wr && acc)  v = wv;
         else if (hwe)        v = hwd;
         if (wr && acc && a inside {FA_ONCE, FA_WO_ONCE}) m_lock[p] = 1'b1;
         m_val[p] = v;
      end
   endtask

   task automatic check_all(input bit in_reset);
      for (int p = 0; p < NP; p++) begin
         fld_acc_e     a  = fld_acc_e'(p);
         logic [W-1:0] ef = m_val[p];
         logic [W-1:0] ep = (a == FA_PLS1_COMB) ? (wr ? wd : 8'h00)
                          : (a inside {FA_PLS1_REG, FA_PLS0_REG}) ? m_val[p] : 8'h00;
         logic [W-1:0] er = can_read(a) ? m_val[p] : 8'h00;
         string        tg = in_reset ? "R12"
                          : (hwe && (rd || wr) && !is_pulse(a)) ? "R11" : req_of(a);
         checks++;
         if (fo[p] !== ef || po[p] !== ep || ro[p] !== er) begin
            errors++;
            $display("FAIL %s %s field %h exp %h pulse %h exp %h rdata %h exp %h",
                     tg, a.name(), fo[p], ef, po[p], ep, ro[p], er);
         end
      end
   endtask

   function automatic logic [W-1:0] pick_data();
      case ($urandom % 4)
         0:       return 8'h00;
         1:       return 8'hFF;
         default: return W'($urandom);
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; hwe = 1'b0; wd = '0; hwd = '0;
      repeat (2) @(negedge clk);
      model_reset();
      check_all(1'b1);                       // R12 reset state
      rst_n = 1'b1;
      for (int n = 0; n < 4000; n++) begin
         rd  = ($urandom % 4) == 0;
         wr  = ($urandom % 3) == 0;
         hwe = ($urandom % 4) == 0;
         wd  = pick_data();
         hwd = pick_data();
         if (n % 700 == 350) begin
            rst_n = 1'b0;                    // R12 mid-traffic reset, lock cleared
            @(negedge clk);
            model_reset();
            check_all(1'b1);
            rst_n = 1'b1;
         end else begin
            @(negedge clk);
            model_step();
            check_all(1'b0);
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule